// File: doc/BRIEF.md
# Integer Ratio Video Scaler

This block resizes a one-pixel-per-clock video stream by a factor of two in either direction, or forwards it untouched. Pixels arrive and leave on valid/ready streams. Each beat carries a start-of-frame flag on the first pixel of a frame and an end-of-line flag on the last pixel of each line. A small write port holds a pending mode and input line width. The scaler switches to these values only when it accepts the first pixel of the next frame, so every frame is scaled with one setting from start to end.

Enlarging repeats every pixel and every line. An even output line is built directly from the input while a copy of the line is written into a single line store. The odd output line that follows is replayed from that store, and no input is taken during the replay. Shrinking keeps the even-indexed pixels of the even-indexed lines and consumes the rest, so the output comes in bursts. The input side is driven by the downstream in passthrough and on the kept pixels. On discarded pixels the input is always taken.

Top module: `vscale2x`

## Requirements
- R1: Mode code 0 is passthrough (code 3 behaves the same). Every input beat is forwarded unchanged with its start-of-frame and end-of-line flags, and in_ready follows out_ready.
- R2: Mode code 2 is downscale. The output holds, in order, the pixels at even column index (counted from 0) of each even-indexed input line.
- R3: In downscale with continuous input and a ready downstream, out_valid is high on alternate input pixels of even lines and low for every pixel of odd lines. Discarded pixels are accepted even while out_ready is low.
- R4: Mode code 1 is upscale. Every input pixel is emitted twice in a row, and every output line is followed by an identical line replayed from the line store.
- R5: In upscale with continuous input and a ready downstream, out_valid is high on every cycle of the frame. Input is accepted only on the first copy of each pixel of an even output line and never during a replayed line.
- R6: In every mode, out_sof marks the first output pixel of a frame and out_eol marks the last output pixel of every output line. In downscale the last kept column is derived from the configured width.
- R7: A configuration write sets only the pending mode and width. These take effect when a start-of-frame pixel is accepted, so a write during a frame leaves that frame unchanged and governs the next one.
- R8: While out_ready is low, no counter, replay position or pixel advances. Under any ready and valid pattern, no output pixel is lost or duplicated.
- R9: Reset clears the duplicate and replay state, drops out_valid, and selects passthrough with the width set to the line store depth. Line and pixel parity restart at every accepted start-of-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads cfg_mode and cfg_width into the pending settings |
| cfg_mode | input | 2 | 0 passthrough, 1 upscale, 2 downscale, 3 passthrough |
| cfg_width | input | WW | Input pixels per line, 1 to MAXW |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat taken at this edge when in_valid is high |
| in_data | input | DW | Input pixel |
| in_sof | input | 1 | Input beat is the first pixel of a frame |
| in_eol | input | 1 | Input beat is the last pixel of a line |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | DW | Output pixel |
| out_sof | output | 1 | First output pixel of a frame |
| out_eol | output | 1 | Last output pixel of an output line |

## Verification
Each mode is driven with even and odd widths and heights, so column and line parity and the last kept column are exercised at both ends of a line. Continuous input with a ready downstream isolates the cycle pattern of each mode: bursts in downscale, and gated input under a steady output in upscale. Gapped input, alternating ready and pseudo-random ready then show that stalls change only the timing and never the pixel sequence. A configuration write in mid-frame and a reset in mid-frame tell apart a pending setting from an applied one and leftover replay state from a clean restart.

// File: rtl/vscale2x.sv
module vscale2x #(
  parameter int DW = 24,
  parameter int MAXW = 1920,
  localparam int WW = $clog2(MAXW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic [WW-1:0] cfg_width,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eol,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_sof,
  output logic          out_eol
);
  localparam logic [1:0] M_PASS = 2'd0;
  localparam logic [1:0] M_UP   = 2'd1;
  localparam logic [1:0] M_DOWN = 2'd2;
  localparam logic [WW-1:0] LASTI = WW'(MAXW - 1);

  logic [1:0]    act_mode, pend_mode;
  logic [WW-1:0] act_w, pend_w;
  logic [WW-1:0] col, rd;
  logic          line_odd, dup, rep, rdup, hold_eol;
  logic [DW-1:0] hold;
  logic [DW-1:0] lb [MAXW];

  logic          ov, osof;

  wire           take_new = in_valid && in_sof && !dup && !rep;
  wire [1:0]     mode_e   = take_new ? pend_mode : act_mode;
  wire [WW-1:0]  w_e      = take_new ? pend_w : act_w;
  wire [WW-1:0]  w_m1     = w_e - 1'b1;
  wire [WW-1:0]  col_e    = in_sof ? '0 : col;
  wire           line_e   = in_sof ? 1'b0 : line_odd;
  wire           keep     = !line_e && !col_e[0];
  wire           is_up    = (mode_e == M_UP);
  wire           is_dn    = (mode_e == M_DOWN);
  wire           acc      = in_valid && in_ready;

  always_comb begin
    in_ready = 1'b0;
    ov       = 1'b0;
    osof     = 1'b0;
    out_eol  = 1'b0;
    out_data = in_data;
    if (is_up) begin
      if (rep) begin
        ov       = 1'b1;
        out_data = lb[rd];
        out_eol  = rdup && (rd == w_m1);
      end else if (dup) begin
        ov       = 1'b1;
        out_data = hold;
        out_eol  = hold_eol;
      end else begin
        in_ready = out_ready;
        ov       = in_valid;
        osof     = in_sof;
      end
    end else if (is_dn) begin
      in_ready = keep ? out_ready : 1'b1;
      ov       = in_valid && keep;
      osof     = in_sof;
      out_eol  = ov && (col_e == {w_m1[WW-1:1], 1'b0});
    end else begin
      in_ready = out_ready;
      ov       = in_valid;
      osof     = in_sof;
      out_eol  = in_valid && in_eol;
    end
  end

  assign out_valid = ov;
  assign out_sof   = ov && osof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_mode  <= M_PASS;
      pend_mode <= M_PASS;
      act_w     <= WW'(MAXW);
      pend_w    <= WW'(MAXW);
      col       <= '0;
      line_odd  <= 1'b0;
      dup       <= 1'b0;
      rep       <= 1'b0;
      rdup      <= 1'b0;
      rd        <= '0;
      hold      <= '0;
      hold_eol  <= 1'b0;
    end else begin
      if (cfg_we) begin
        pend_mode <= cfg_mode;
        pend_w    <= cfg_width;
      end
      if (acc) begin
        col      <= in_eol ? '0 : col_e + 1'b1;
        line_odd <= in_eol ? !line_e : line_e;
        if (take_new) begin
          act_mode <= pend_mode;
          act_w    <= pend_w;
        end
      end
      if (is_up) begin
        if (rep) begin
          if (out_ready) begin
            rdup <= !rdup;
            if (rdup) begin
              rd <= rd + 1'b1;
              if (rd == w_m1) rep <= 1'b0;
            end
          end
        end else if (dup) begin
          if (out_ready) begin
            dup <= 1'b0;
            if (hold_eol) begin
              rep  <= 1'b1;
              rd   <= '0;
              rdup <= 1'b0;
            end
          end
        end else if (acc) begin
          dup      <= 1'b1;
          hold     <= in_data;
          hold_eol <= in_eol;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc && is_up && !rep && !dup && col_e <= LASTI)
      lb[col_e] <= in_data;
  end
endmodule

// File: rtl/vscale2x_chk.sv
module vscale2x_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    act_mode,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_sof,
  input logic          in_eol,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data
);
  localparam logic [1:0] C_PASS = 2'd0;
  localparam logic [1:0] C_UP   = 2'd1;
  localparam logic [1:0] C_DOWN = 2'd2;

  a_r1_pass_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == C_PASS && !(in_valid && in_sof)) |-> (out_valid == in_valid && in_ready == out_ready));

  a_r3_skip_after_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == C_DOWN && out_valid && out_ready && !in_eol && !in_sof) |=> (in_sof || !out_valid));

  a_r5_no_back_to_back_take: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == C_UP && in_valid && in_ready) |=> (act_mode != C_UP || !in_ready));

  a_r7_mode_held_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && in_sof) |=> $stable(act_mode));

  a_r8_stall_holds_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == C_UP && out_valid && !out_ready && !in_valid) |=> (out_valid && $stable(out_data)));
endmodule

bind vscale2x vscale2x_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_mode(act_mode),
  .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_eol(in_eol),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/vscale2x_test.sv
module vscale2x_test;
  localparam int CLK_P = 10;
  localparam int DW = 8;
  localparam int MAXW = 1920;
  localparam int WW = $clog2(MAXW + 1);
  localparam int NV = 8;
  // mode, width, height, ready pattern, valid pattern, expected output count
  localparam int VEC [NV][6] = '{
    '{0, 4, 3, 0, 0, 12},
    '{0, 5, 2, 2, 2, 10},
    '{2, 4, 4, 0, 0, 4},
    '{2, 5, 3, 1, 2, 6},
    '{1, 3, 2, 0, 0, 24},
    '{1, 4, 3, 2, 1, 48},
    '{2, 6, 2, 2, 0, 3},
    '{1, 2, 1, 1, 0, 8}
  };

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_mode = 0;
  logic [WW-1:0] cfg_width = 0;
  logic in_valid = 0, in_sof = 0, in_eol = 0, out_ready = 1;
  logic [DW-1:0] in_data = 0;
  logic in_ready, out_valid, out_sof, out_eol;
  logic [DW-1:0] out_data;
  logic [15:0] lfsr = 16'hACE1;
  logic [DW+1:0] expq [0:1023];
  int total = 0, bad = 0;

  vscale2x #(.DW(DW), .MAXW(MAXW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_width(cfg_width),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [DW-1:0] pix(int l, int c);
    return {l[3:0], c[3:0]};
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int build_exp(int mode, int w, int h);
    int n = 0;
    for (int l = 0; l < h; l++) begin
      if (mode == 1) begin
        for (int r = 0; r < 2; r++)
          for (int c = 0; c < w; c++)
            for (int k = 0; k < 2; k++) begin
              expq[n] = {1'(l == 0 && r == 0 && c == 0 && k == 0), 1'(c == w-1 && k == 1), pix(l, c)};
              n++;
            end
      end else if (mode == 2) begin
        if (l % 2 == 0)
          for (int c = 0; c < w; c += 2) begin
            expq[n] = {1'(l == 0 && c == 0), 1'(c == ((w-1) & ~1)), pix(l, c)};
            n++;
          end
      end else begin
        for (int c = 0; c < w; c++) begin
          expq[n] = {1'(l == 0 && c == 0), 1'(c == w-1), pix(l, c)};
          n++;
        end
      end
    end
    return n;
  endfunction

  task automatic write_cfg(int mode, int w);
    @(negedge clk);
    cfg_we = 1; cfg_mode = 2'(mode); cfg_width = WW'(w);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run_frame(int mode, int w, int h, int rpat, int vpat, bit mid, int nexp_tab);
    int tot = w * h;
    int n = build_exp(mode, w, h);
    int ii = 0, oc = 0, cyc = 0;
    string tg;
    tg = (mode == 1) ? "R4/R6" : (mode == 2) ? "R2/R6" : "R1/R6";
    if (rpat != 0 || vpat != 0) tg = {tg, "/R8"};
    if (mid) tg = {tg, "/R7"};
    if (nexp_tab >= 0) chk(n == nexp_tab, "table output count R2 R4", n, nexp_tab);
    while ((ii < tot || oc < n) && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cfg_we = 0;
      if (mid && ii == 2 && cyc < 6) begin
        cfg_we = 1; cfg_mode = 2'd0; cfg_width = WW'(w);
      end
      in_valid = (ii < tot) && (vpat == 0 || (vpat == 1 && cyc[0]) || (vpat == 2 && lfsr[0]));
      in_data = pix(ii / w, ii % w);
      in_sof = (ii == 0);
      in_eol = (ii % w == w - 1);
      out_ready = (rpat == 0) || (rpat == 1 && !cyc[0]) || (rpat == 2 && lfsr[3]);
      #(CLK_P/4);
      if (mode == 2 && rpat == 0 && vpat == 0 && in_valid)
        chk(out_valid == ((ii / w) % 2 == 0 && (ii % w) % 2 == 0), "R3 burst cadence", out_valid, !out_valid);
      if (mode == 2 && in_valid && !out_ready && (ii / w) % 2 == 1)
        chk(in_ready == 1'b1, "R3 odd line taken under stall", in_ready, 1);
      if (mode == 1 && rpat == 0 && vpat == 0 && oc < n) begin
        chk(out_valid == 1'b1, "R5 output every cycle", out_valid, 1);
        chk(in_ready == ((oc % (4*w)) < 2*w && oc % 2 == 0), "R5 input gating", in_ready,
            (oc % (4*w)) < 2*w && oc % 2 == 0);
      end
      if (out_valid && out_ready) begin
        if (oc < n)
          chk({out_sof, out_eol, out_data} == expq[oc], tg, {out_sof, out_eol, out_data}, expq[oc]);
        else
          chk(1'b0, {tg, " extra output"}, {out_sof, out_eol, out_data}, 0);
        oc++;
      end
      if (in_valid && in_ready) ii++;
    end
    @(negedge clk);
    in_valid = 0; cfg_we = 0; out_ready = 1;
    chk(oc == n, {tg, " output count"}, oc, n);
    chk(ii == tot, {tg, " input count"}, ii, tot);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #(CLK_P/4);
    chk(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    #(CLK_P/4);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R9 idle passthrough after reset", {out_valid, in_ready}, 2'b01);

    for (int v = 0; v < NV; v++) begin
      write_cfg(VEC[v][0], VEC[v][1]);
      run_frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 1'b0, VEC[v][5]);
    end

    // R7: write in mid-frame keeps upscale for this frame, passthrough for the next
    write_cfg(1, 4);
    run_frame(1, 4, 2, 0, 0, 1'b1, 32);
    run_frame(0, 4, 2, 0, 0, 1'b1, 8);

    // R9: reset while upscale duplicate state is pending
    write_cfg(1, 3);
    @(negedge clk);
    in_valid = 1; in_sof = 1; in_eol = 0; in_data = 8'h5A; out_ready = 1;
    @(negedge clk);
    in_valid = 0; in_sof = 0;
    #(CLK_P/4);
    chk(out_valid == 1'b1 && out_data == 8'h5A, "R4 second copy before reset", {out_valid, out_data}, {1'b1, 8'h5A});
    rst_n = 0;
    @(negedge clk);
    #(CLK_P/4);
    chk(out_valid == 1'b0, "R9 reset clears duplicate", out_valid, 0);
    rst_n = 1;
    run_frame(0, 3, 2, 1, 0, 1'b0, 6);

    // R9: restart parity when a frame is cut short in downscale
    write_cfg(2, 4);
    @(negedge clk);
    in_valid = 1; in_sof = 1; in_eol = 0; in_data = 8'h11;
    @(negedge clk);
    in_valid = 0; in_sof = 0;
    run_frame(2, 4, 2, 0, 0, 1'b0, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule